// File: doc/BRIEF.md
# Indirect Configuration Access Port Decoder

This block sits behind the host I/O port bus of a host bridge and implements the two-window indirect scheme used to reach function configuration registers on bus zero. Software first writes a 32-bit selector into the address window. That selector carries an enable bit, a bus number, a device/function slot and a dword register index. Software then reads or writes the data window with byte, word or dword width. The decoder checks the selector, combines the dword index with the low bits of the data-window address, and forwards a qualified request to the function side. The request carries a slot number, a byte offset, a byte count, a direction and the write data.

A 256-bit presence vector from the surrounding fabric marks which slots hold a function. The decoder drops any data write that fails the selector checks or lands on an empty slot. A read in the same situation returns all-ones of the access width, as happens on a bus where no target claims the cycle. The function side answers a forwarded read in the same cycle. The decoder returns every read that hits either window on the host side with a one-cycle registered response.

Top module: `cfg_port_decoder`

## Requirements
- R1: Reset clears the selector register to zero and holds `io_rvalid` low, so the data window stays closed until software programs the selector.
- R2: A dword access at the exact base of the address window writes the selector. A dword read there returns the last value written, with `io_rvalid` high on the following cycle.
- R3: Byte or word accesses to the address window, and dword accesses not aligned to its base, leave the selector unchanged. Such reads return all-ones of the access width.
- R4: A data-window access is forwarded (`cfg_valid` high in the same cycle) only when selector bit 31 is set, selector bits 1:0 are zero, selector bits 23:16 are zero, and the slot given by selector bits 15:8 is marked present.
- R5: A forwarded request carries `cfg_slot` = selector bits 15:8 and `cfg_offset` = {selector bits 7:2, I/O address bits 1:0}. It also carries the access direction and `io_wdata` unchanged.
- R6: A data-window read that is not forwarded returns 0xFF, 0xFFFF or 0xFFFFFFFF for byte, word or dword width, one cycle later.
- R7: A data-window write that is not forwarded produces no request on the function side.
- R8: A forwarded read returns `cfg_rdata` one cycle later, with bits above the access width forced to zero.
- R9: The width code on `io_size` is 0 = byte, 1 = word, 2 = dword, and 3 is taken as dword. `cfg_bytes` reports 1, 2 or 4 accordingly.
- R10: An access outside both 4-byte windows produces no request, no response, and no change to the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_req | input | 1 | Host I/O access strobe, one cycle per access |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Host I/O port address |
| io_size | input | 2 | Access width code (0 byte, 1 word, 2/3 dword) |
| io_wdata | input | 32 | Host write data, right-justified |
| io_rdata | output | 32 | Registered read data |
| io_rvalid | output | 1 | Read response valid, one cycle after a read hitting either window |
| slot_present | input | 256 | One bit per slot, 1 = function present |
| cfg_valid | output | 1 | Forwarded request strobe |
| cfg_write | output | 1 | Forwarded request direction |
| cfg_slot | output | 8 | Target device/function slot |
| cfg_offset | output | 8 | Byte offset in the function's register space |
| cfg_bytes | output | 3 | Byte count: 1, 2 or 4 |
| cfg_wdata | output | 32 | Forwarded write data |
| cfg_rdata | input | 32 | Function read data, valid in the request cycle |

## Verification
The host port carries one access per cycle, so at some edges two things happen together. One is a selector update that has just been written. The other is the registered response of the previous read, still on `io_rdata` while the next access is already being decoded. The bench issues accesses with no idle cycle between them, for example a selector write followed at once by a data read, and a data read followed at once by another read. It then checks two things. The second access must use the new selector in its forwarding decision. The response seen in each cycle must belong to the earlier read, with width and all-ones value taken from that read's own size code.

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder #(
  parameter logic [15:0] ADDR_PORT = 16'hCF8,
  parameter logic [15:0] DATA_PORT = 16'hCFC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         io_req,
  input  logic         io_wr,
  input  logic [15:0]  io_addr,
  input  logic [1:0]   io_size,
  input  logic [31:0]  io_wdata,
  output logic [31:0]  io_rdata,
  output logic         io_rvalid,
  input  logic [255:0] slot_present,
  output logic         cfg_valid,
  output logic         cfg_write,
  output logic [7:0]   cfg_slot,
  output logic [7:0]   cfg_offset,
  output logic [2:0]   cfg_bytes,
  output logic [31:0]  cfg_wdata,
  input  logic [31:0]  cfg_rdata
);

  logic [31:0] addr_q;
  logic        addr_win, data_win, sel_ok, gate_ok, rd_hit;
  logic [31:0] width_ones, rdata_d;

  assign addr_win = io_req && (io_addr[15:2] == ADDR_PORT[15:2]);
  assign data_win = io_req && (io_addr[15:2] == DATA_PORT[15:2]);
  assign sel_ok   = addr_win && io_size[1] && (io_addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (sel_ok && io_wr)
      addr_q <= io_wdata;
  end

  assign gate_ok = addr_q[31] && (addr_q[1:0] == 2'b00) &&
                   (addr_q[23:16] == 8'h00) && slot_present[addr_q[15:8]];

  assign cfg_valid  = data_win && gate_ok;
  assign cfg_write  = io_wr;
  assign cfg_slot   = addr_q[15:8];
  assign cfg_offset = {addr_q[7:2], io_addr[1:0]};
  assign cfg_wdata  = io_wdata;

  always_comb begin
    case (io_size)
      2'd0:    begin width_ones = 32'h0000_00FF; cfg_bytes = 3'd1; end
      2'd1:    begin width_ones = 32'h0000_FFFF; cfg_bytes = 3'd2; end
      default: begin width_ones = 32'hFFFF_FFFF; cfg_bytes = 3'd4; end
    endcase
  end

  assign rd_hit  = (addr_win || data_win) && !io_wr;
  assign rdata_d = sel_ok    ? addr_q :
                   cfg_valid ? (cfg_rdata & width_ones) : width_ones;

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= rd_hit;
      io_rdata  <= rd_hit ? rdata_d : '0;
    end
  end

endmodule

// File: rtl/cfg_port_decoder_chk.sv
module cfg_port_decoder_chk #(
  parameter logic [15:0] ADDR_PORT = 16'hCF8,
  parameter logic [15:0] DATA_PORT = 16'hCFC
) (
  input logic         clk,
  input logic         rst,
  input logic         io_req,
  input logic         io_wr,
  input logic [15:0]  io_addr,
  input logic [1:0]   io_size,
  input logic [31:0]  io_rdata,
  input logic         io_rvalid,
  input logic [255:0] slot_present,
  input logic         cfg_valid,
  input logic [7:0]   cfg_slot,
  input logic [7:0]   cfg_offset,
  input logic [31:0]  addr_q
);

  logic in_addr, in_data, data_rd_drop, sel_wr;
  logic [31:0] ones_now;

  assign in_addr      = io_req && (io_addr[15:2] == ADDR_PORT[15:2]);
  assign in_data      = io_req && (io_addr[15:2] == DATA_PORT[15:2]);
  assign data_rd_drop = in_data && !io_wr && !cfg_valid;
  assign sel_wr       = in_addr && io_wr && io_size[1] && (io_addr[1:0] == 2'b00);
  assign ones_now     = (io_size == 2'd0) ? 32'hFF : (io_size == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;

  a_r4_fwd_needs_gate: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (addr_q[31] && addr_q[1:0] == 2'b00 && addr_q[23:16] == 8'h00 && slot_present[cfg_slot]));

  a_r5_offset_index: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (cfg_offset[7:2] == addr_q[7:2] && cfg_offset[1:0] == io_addr[1:0]));

  a_r6_drop_ones: assert property (@(posedge clk) disable iff (rst)
    data_rd_drop |=> (io_rvalid && io_rdata == $past(ones_now)));

  a_r3_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !sel_wr |=> $stable(addr_q));

  a_r10_outside_quiet: assert property (@(posedge clk) disable iff (rst)
    (!in_addr && !in_data) |-> !cfg_valid);

  a_r2_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    io_rvalid |-> $past(io_req && !io_wr));

endmodule

bind cfg_port_decoder cfg_port_decoder_chk #(.ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_chk (
  .clk(clk), .rst(rst), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
  .io_size(io_size), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
  .slot_present(slot_present), .cfg_valid(cfg_valid), .cfg_slot(cfg_slot),
  .cfg_offset(cfg_offset), .addr_q(addr_q)
);

// File: tb/test_cfg_port_decoder.sv
module test_cfg_port_decoder;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         io_req, io_wr;
  logic [15:0]  io_addr;
  logic [1:0]   io_size;
  logic [31:0]  io_wdata, io_rdata;
  logic         io_rvalid;
  logic [255:0] slot_present;
  logic         cfg_valid, cfg_write;
  logic [7:0]   cfg_slot, cfg_offset;
  logic [2:0]   cfg_bytes;
  logic [31:0]  cfg_wdata, cfg_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] m_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_decoder i_cfg_port_decoder (
    .clk(clk), .rst(rst), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
    .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .slot_present(slot_present), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
    .cfg_slot(cfg_slot), .cfg_offset(cfg_offset), .cfg_bytes(cfg_bytes),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [31:0] dev_fn(input logic [7:0] s, input logic [7:0] o);
    return {s, o, 8'hA5, s ^ o};
  endfunction

  assign cfg_rdata = dev_fn(cfg_slot, cfg_offset);

  function automatic logic [31:0] ones_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [2:0] bytes_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Starts at a falling edge, leaves at the next falling edge with io_req low.
  task automatic acc(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, input string tag);
    bit aw, dw, aok, fwd, rd_hit;
    logic [31:0] exp_rd;
    io_req = 1'b1; io_wr = wr; io_addr = a; io_size = sz; io_wdata = wd;
    aw  = (a[15:2] == 14'h33E);
    dw  = (a[15:2] == 14'h33F);
    aok = aw && sz[1] && (a[1:0] == 2'b00);
    fwd = dw && m_addr[31] && (m_addr[1:0] == 2'b00) && (m_addr[23:16] == 8'h00)
             && slot_present[m_addr[15:8]];
    rd_hit = (aw || dw) && !wr;
    exp_rd = aok ? m_addr :
             fwd ? (dev_fn(m_addr[15:8], {m_addr[7:2], a[1:0]}) & ones_of(sz)) : ones_of(sz);
    #1;
    chk(cfg_valid === fwd, tag, "cfg_valid", {31'd0, cfg_valid}, {31'd0, fwd});
    if (fwd) begin
      chk(cfg_slot === m_addr[15:8], tag, "cfg_slot", {24'd0, cfg_slot}, {24'd0, m_addr[15:8]});
      chk(cfg_offset === {m_addr[7:2], a[1:0]}, tag, "cfg_offset", {24'd0, cfg_offset},
          {24'd0, m_addr[7:2], a[1:0]});
      chk(cfg_bytes === bytes_of(sz), tag, "cfg_bytes R9", {29'd0, cfg_bytes}, {29'd0, bytes_of(sz)});
      chk(cfg_write === wr, tag, "cfg_write", {31'd0, cfg_write}, {31'd0, wr});
      if (wr) chk(cfg_wdata === wd, tag, "cfg_wdata", cfg_wdata, wd);
    end
    @(negedge clk);
    chk(io_rvalid === rd_hit, tag, "io_rvalid", {31'd0, io_rvalid}, {31'd0, rd_hit});
    if (rd_hit) chk(io_rdata === exp_rd, tag, "io_rdata", io_rdata, exp_rd);
    if (wr && aok) m_addr = wd;
    io_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; io_req = 1'b0; io_wr = 1'b0; io_addr = '0; io_size = '0; io_wdata = '0;
    for (int i = 0; i < 256; i++) slot_present[i] = (i % 3 == 0);
    slot_present[255] = 1'b1;
    m_addr = '0;
    repeat (3) @(negedge clk);
    chk(io_rvalid === 1'b0, "R1", "rvalid in reset", {31'd0, io_rvalid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(io_rvalid === 1'b0, "R1", "rvalid after reset", {31'd0, io_rvalid}, 32'd0);
    acc(0, 16'hCF8, 2'd2, 0, "R1");
    acc(0, 16'hCFC, 2'd2, 0, "R1");

    acc(1, 16'hCF8, 2'd2, 32'h8000_0104, "R2");
    acc(0, 16'hCF8, 2'd2, 0, "R2");
    acc(0, 16'hCFC, 2'd2, 0, "R6");
    acc(0, 16'hCFD, 2'd0, 0, "R6");
    acc(0, 16'hCFE, 2'd1, 0, "R6");
    acc(1, 16'hCFC, 2'd2, 32'h1234_5678, "R7");

    acc(1, 16'hCF8, 2'd2, 32'h8000_0008, "R2");
    acc(0, 16'hCFE, 2'd1, 0, "R8");
    acc(0, 16'hCFF, 2'd0, 0, "R8");
    acc(0, 16'hCFC, 2'd3, 0, "R9");
    acc(1, 16'hCFD, 2'd0, 32'h0000_00C3, "R5");

    acc(1, 16'hCF8, 2'd2, 32'h0000_0008, "R4");
    acc(0, 16'hCFC, 2'd2, 0, "R4");
    acc(1, 16'hCFC, 2'd1, 32'hBEEF, "R7");
    acc(1, 16'hCF8, 2'd2, 32'h8001_0008, "R4");
    acc(0, 16'hCFC, 2'd2, 0, "R4");
    acc(1, 16'hCF8, 2'd2, 32'h8000_0009, "R4");
    acc(0, 16'hCFC, 2'd1, 0, "R4");

    acc(1, 16'hCF8, 2'd0, 32'hFFFF_FFFF, "R3");
    acc(1, 16'hCF8, 2'd1, 32'hFFFF_FFFF, "R3");
    acc(1, 16'hCF9, 2'd2, 32'hFFFF_FFFF, "R3");
    acc(0, 16'hCF8, 2'd2, 0, "R3");
    acc(0, 16'hCF8, 2'd0, 0, "R3");
    acc(0, 16'hCFA, 2'd1, 0, "R3");

    acc(0, 16'h0080, 2'd2, 0, "R10");
    acc(1, 16'hCF4, 2'd2, 32'h8000_FF00, "R10");
    acc(0, 16'hCF8, 2'd2, 0, "R10");

    acc(1, 16'hCF8, 2'd2, 32'h8000_FFFC, "R5");
    acc(1, 16'hCFF, 2'd0, 32'h5A, "R5");
    acc(0, 16'hCFC, 2'd2, 0, "R5");
    acc(0, 16'hCFD, 2'd1, 0, "R5");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r, v;
      logic [15:0] a;
      r = $urandom;
      if (r[3:0] < 4) begin
        v = $urandom;
        v[31] = (r[4] | r[5]);
        if (r[7:6] != 0) v[23:16] = 8'h00;
        if (r[9:8] != 0) v[1:0] = 2'b00;
        acc(1, 16'hCF8, 2'd2, v, "R4");
      end else begin
        case (r[11:10])
          2'd0:    a = 16'hCF8 + {14'd0, r[13:12]};
          2'd3:    a = 16'hCF0 + {12'd0, r[15:12]};
          default: a = 16'hCFC + {14'd0, r[13:12]};
        endcase
        acc(r[16], a, r[18:17], $urandom, "R8");
      end
    end

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule